// File: doc/BRIEF.md
# Display Adapter Identification I2C Target

This block is an I2C target that sits on a display data channel and lets a source device find out what kind of dual-mode display adapter it is connected to. It answers at the 7-bit bus address 40h, so a write transfer starts with byte 80h and a read transfer starts with byte 81h. It answers only while the active-low select input `selN` is low. The first byte of every write transfer loads an 8-bit subaddress pointer. Any further bytes in that transfer are stored starting at that pointer. A read transfer returns bytes from the pointer onward, and the pointer advances by one after each byte.

The readable contents depend on two inputs. `hdmiMode` chooses between the HDMI and the DVI identification content. `rateSel` chooses the data-rate capability byte. Three writable registers are kept:
- a TMDS disable bit, which drives `tmdsOff`;
- a CEC enable bit, which drives `cecOn`;
- a bus-speed code, which rejects illegal values by falling back to its default.

SCL and SDA are sampled on a system clock that runs at least eight times the bus rate. The target pulls SDA low by asserting `sdaOe`; the pad driver sits outside the block.

Top module: `ddc_id_target`

## Requirements
- R1: Address byte 80h (write) and 81h (read) are acknowledged; any other address byte (for example A0h) is not acknowledged and the target stays silent until the next START.
- R2: While `selN` is high at the address phase, address byte 80h is not acknowledged.
- R3: The first byte of a write transfer sets the pointer. Each later byte in the same transfer is stored at the pointer, and the pointer then increments. The pointer wraps from FFh to 00h.
- R4: A read transfer returns the byte at the pointer, then the pointer increments. After each byte the target releases SDA for the master acknowledge. The transfer continues on ACK (SDA low) and ends on NACK.
- R5: With `hdmiMode`=1, offsets 00h–0Fh read the ASCII text "DP-HDMI ADAPTOR" followed by 04h, and offset 10h reads A0h. With `hdmiMode`=0, offsets 00h–10h read 00h.
- R6: Offset 1Dh reads 88h in HDMI mode and 42h in DVI mode. Offset 1Eh reads 0Fh when `rateSel`=0 and 1Fh when `rateSel`=1. Offsets 11h–1Ch read, in order: A5h C3h F0h 49h 44h 54h 47h 54h 00h 02h 00h 00h.
- R7: Bit 0 of offset 20h drives `tmdsOff` (1 = disabled). Bit 0 of offset 21h drives `cecOn`. Both reset to 0, and bits 7:1 of both read 0.
- R8: Offset 22h resets to 08h. A write of 01h, 02h, 04h, 08h or 10h is stored. Any other written value stores 08h. A read returns the stored value.
- R9: Writes to read-only offsets (00h–1Fh) and to 23h–FFh are acknowledged but change nothing. Offsets 23h–FFh read 00h.
- R10: A START or STOP at any point aborts the transfer in progress. A partly received byte is discarded. A repeated START begins a new address phase.
- R11: The target changes `sdaOe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | 1 pulls SDA low (open drain) |
| selN | input | 1 | Active-low target select |
| hdmiMode | input | 1 | 1 = HDMI content, 0 = DVI content |
| rateSel | input | 1 | Data-rate capability select for offset 1Eh |
| tmdsOff | output | 1 | TMDS output disable, from offset 20h bit 0 |
| cecOn | output | 1 | CEC connection enable, from offset 21h bit 0 |

## Verification
A pointer that is off by one or fails to advance shows up on the very next data byte a master reads: the identification text comes out shifted or repeated. A wrong sequencer state shows up within one bit period as a missing or misplaced acknowledge, or as SDA moving while SCL is high. A control register that takes a partial byte, a rejected speed code or a read-only write shows up on `tmdsOff`, `cecOn` or the next read of offset 22h. That happens within a few system clocks of the acknowledge.

// File: rtl/ddc_id_pkg.sv
package ddc_id_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_WR,
    S_WR_ACK,
    S_RD,
    S_RD_ACK
  } busState_t;

  // One-cycle strobes from the bus sequencer to the register datapath
  typedef struct packed {
    logic       setPtr;
    logic       wrByte;
    logic       incPtr;
    logic [7:0] data;
  } ctrlStb_t;

endpackage

// File: rtl/ddc_id_ctrl.sv
module ddc_id_ctrl
  import ddc_id_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h40,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       selN,
  input  logic [7:0] rdData,
  output ctrlStb_t   stb,
  output logic       sdaOe
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sclPipe, sdaPipe;
  logic          sclD, sdaD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[LAST-1:0], sclIn};
      sdaPipe <= {sdaPipe[LAST-1:0], sdaIn};
      sclD    <= sclPipe[LAST];
      sdaD    <= sdaPipe[LAST];
    end
  end

  logic sclS, sdaS, sclRise, sclFall, startC, stopC;
  assign sclS    = sclPipe[LAST];
  assign sdaS    = sdaPipe[LAST];
  assign sclRise = sclS & ~sclD;
  assign sclFall = ~sclS & sclD;
  assign startC  = sclS & sclD & sdaD & ~sdaS;
  assign stopC   = sclS & sclD & ~sdaD & sdaS;

  busState_t  state;
  logic [3:0] bitCnt;
  logic [7:0] shift;
  logic       isRead, firstByte, mAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      bitCnt    <= '0;
      shift     <= '0;
      sdaOe     <= 1'b0;
      isRead    <= 1'b0;
      firstByte <= 1'b0;
      mAck      <= 1'b0;
      stb       <= '0;
    end else begin
      stb <= '0;
      if (startC) begin
        state  <= S_ADDR;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (stopC) begin
        state <= S_IDLE;
        sdaOe <= 1'b0;
      end else begin
        case (state)
          S_ADDR: begin
            if (sclRise && bitCnt != 4'd8) begin
              shift  <= {shift[6:0], sdaS};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              if (shift[7:1] == DEV_ADDR && !selN) begin
                sdaOe  <= 1'b1;
                isRead <= shift[0];
                state  <= S_ADDR_ACK;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_ADDR_ACK: begin
            if (sclFall) begin
              bitCnt    <= '0;
              firstByte <= 1'b1;
              if (isRead) begin
                shift <= rdData;
                sdaOe <= ~rdData[7];
                state <= S_RD;
              end else begin
                sdaOe <= 1'b0;
                state <= S_WR;
              end
            end
          end
          S_WR: begin
            if (sclRise && bitCnt != 4'd8) begin
              shift  <= {shift[6:0], sdaS};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              sdaOe      <= 1'b1;
              stb.setPtr <= firstByte;
              stb.wrByte <= ~firstByte;
              stb.data   <= shift;
              state      <= S_WR_ACK;
            end
          end
          S_WR_ACK: begin
            if (sclFall) begin
              sdaOe     <= 1'b0;
              bitCnt    <= '0;
              firstByte <= 1'b0;
              state     <= S_WR;
            end
          end
          S_RD: begin
            if (sclRise && bitCnt != 4'd8) begin
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall) begin
              if (bitCnt == 4'd8) begin
                sdaOe      <= 1'b0;
                stb.incPtr <= 1'b1;
                state      <= S_RD_ACK;
              end else if (bitCnt != 4'd0) begin
                shift <= {shift[6:0], 1'b0};
                sdaOe <= ~shift[6];
              end
            end
          end
          S_RD_ACK: begin
            if (sclRise) begin
              mAck <= ~sdaS;
            end else if (sclFall) begin
              if (mAck) begin
                shift  <= rdData;
                sdaOe  <= ~rdData[7];
                bitCnt <= '0;
                state  <= S_RD;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/ddc_id_regs.sv
module ddc_id_regs
  import ddc_id_pkg::*;
#(
  parameter logic [23:0] OUI_CODE  = 24'hA5C3F0,
  parameter logic [47:0] DEV_ID    = 48'h4944_5447_5400,
  parameter logic [7:0]  HW_REV    = 8'h02,
  parameter logic [7:0]  TMDS_HDMI = 8'h88,
  parameter logic [7:0]  TMDS_DVI  = 8'h42,
  parameter logic [7:0]  SPEED_DEF = 8'h08
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctrlStb_t   stb,
  input  logic       hdmiMode,
  input  logic       rateSel,
  output logic [7:0] rdData,
  output logic [7:0] ptr,
  output logic [7:0] speed,
  output logic       tmdsOff,
  output logic       cecOn
);

  localparam logic [7:0] OFS_TMDS  = 8'h20;
  localparam logic [7:0] OFS_CEC   = 8'h21;
  localparam logic [7:0] OFS_SPEED = 8'h22;

  function automatic logic [7:0] idChar(input logic [3:0] idx);
    case (idx)
      4'h0: idChar = "D";
      4'h1: idChar = "P";
      4'h2: idChar = "-";
      4'h3: idChar = "H";
      4'h4: idChar = "D";
      4'h5: idChar = "M";
      4'h6: idChar = "I";
      4'h7: idChar = " ";
      4'h8: idChar = "A";
      4'h9: idChar = "D";
      4'hA: idChar = "A";
      4'hB: idChar = "P";
      4'hC: idChar = "T";
      4'hD: idChar = "O";
      4'hE: idChar = "R";
      default: idChar = 8'h04;
    endcase
  endfunction

  logic legalSpeed;
  assign legalSpeed = (stb.data == 8'h01) || (stb.data == 8'h02) ||
                      (stb.data == 8'h04) || (stb.data == 8'h08) ||
                      (stb.data == 8'h10);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      speed   <= SPEED_DEF;
      tmdsOff <= 1'b0;
      cecOn   <= 1'b0;
    end else begin
      if (stb.setPtr) begin
        ptr <= stb.data;
      end else if (stb.wrByte) begin
        ptr <= ptr + 8'd1;
        case (ptr)
          OFS_TMDS:  tmdsOff <= stb.data[0];
          OFS_CEC:   cecOn   <= stb.data[0];
          OFS_SPEED: speed   <= legalSpeed ? stb.data : SPEED_DEF;
          default: ;
        endcase
      end else if (stb.incPtr) begin
        ptr <= ptr + 8'd1;
      end
    end
  end

  always_comb begin
    if (ptr < 8'h10) begin
      rdData = hdmiMode ? idChar(ptr[3:0]) : 8'h00;
    end else begin
      case (ptr)
        8'h10:     rdData = hdmiMode ? 8'hA0 : 8'h00;
        8'h11:     rdData = OUI_CODE[23:16];
        8'h12:     rdData = OUI_CODE[15:8];
        8'h13:     rdData = OUI_CODE[7:0];
        8'h14:     rdData = DEV_ID[47:40];
        8'h15:     rdData = DEV_ID[39:32];
        8'h16:     rdData = DEV_ID[31:24];
        8'h17:     rdData = DEV_ID[23:16];
        8'h18:     rdData = DEV_ID[15:8];
        8'h19:     rdData = DEV_ID[7:0];
        8'h1A:     rdData = HW_REV;
        8'h1D:     rdData = hdmiMode ? TMDS_HDMI : TMDS_DVI;
        8'h1E:     rdData = rateSel ? 8'h1F : 8'h0F;
        OFS_TMDS:  rdData = {7'b0, tmdsOff};
        OFS_CEC:   rdData = {7'b0, cecOn};
        OFS_SPEED: rdData = speed;
        default:   rdData = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/ddc_id_target.sv
module ddc_id_target
  import ddc_id_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h40,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe,
  input  logic selN,
  input  logic hdmiMode,
  input  logic rateSel,
  output logic tmdsOff,
  output logic cecOn
);

  ctrlStb_t   stb;
  logic [7:0] rdData, ptr, speed;

  ddc_id_ctrl #(
    .DEV_ADDR   (DEV_ADDR),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .selN  (selN),
    .rdData(rdData),
    .stb   (stb),
    .sdaOe (sdaOe)
  );

  ddc_id_regs u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .hdmiMode(hdmiMode),
    .rateSel (rateSel),
    .rdData  (rdData),
    .ptr     (ptr),
    .speed   (speed),
    .tmdsOff (tmdsOff),
    .cecOn   (cecOn)
  );

endmodule

// File: rtl/ddc_id_checker.sv
module ddc_id_checker
  import ddc_id_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaOe,
  input ctrlStb_t   stb,
  input logic [7:0] ptr,
  input logic [7:0] speed,
  input logic       tmdsOff,
  input logic       cecOn
);

  p_speed_legal_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(speed) == 1) && (speed[7:5] == 3'b000));

  p_tmds_write_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(tmdsOff) |-> ($past(stb.wrByte) && $past(ptr) == 8'h20));

  p_cec_write_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cecOn) |-> ($past(stb.wrByte) && $past(ptr) == 8'h21));

  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incPtr || stb.wrByte) |=> (ptr == $past(ptr) + 8'd1));

  p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

endmodule

bind ddc_id_target ddc_id_checker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .sclIn  (sclIn),
  .sdaOe  (sdaOe),
  .stb    (stb),
  .ptr    (ptr),
  .speed  (speed),
  .tmdsOff(tmdsOff),
  .cecOn  (cecOn)
);

// File: tb/ddc_id_target_bench.sv
module ddc_id_target_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic selN = 1'b0, hdmiMode = 1'b1, rateSel = 1'b0;
  logic sdaOe, tmdsOff, cecOn;
  logic sdaLine;
  assign sdaLine = mSda & ~sdaOe;

  ddc_id_target u_ddc_id_target (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .selN(selN), .hdmiMode(hdmiMode), .rateSel(rateSel),
    .tmdsOff(tmdsOff), .cecOn(cecOn)
  );

  localparam int Q = 10;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } expItem_t;

  expItem_t   expQ[$];
  logic [7:0] gotQ[$];
  int nChk = 0, nFail = 0;
  bit done = 0;

  logic [7:0] idStr[16] = '{8'h44, 8'h50, 8'h2D, 8'h48, 8'h44, 8'h4D, 8'h49, 8'h20,
                            8'h41, 8'h44, 8'h41, 8'h50, 8'h54, 8'h4F, 8'h52, 8'h04};
  logic [7:0] fixedId[12] = '{8'hA5, 8'hC3, 8'hF0, 8'h49, 8'h44, 8'h54,
                              8'h47, 8'h54, 8'h00, 8'h02, 8'h00, 8'h00};

  task automatic check(input bit ok, input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  // Scoreboard monitor: compares each byte read off the bus with the next expectation
  initial begin
    forever begin
      @(negedge clk);
      while (gotQ.size() > 0) begin
        logic [7:0] g;
        g = gotQ.pop_front();
        if (expQ.size() == 0) begin
          check(1'b0, "R4 unexpected byte", g, 8'h00);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(g == e.val, e.tag, g, e.val);
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; hq(); mScl = 1'b1; hq(); mSda = 1'b0; hq(); mScl = 1'b0; hq();
  endtask

  task automatic busStop();
    mSda = 1'b0; hq(); mScl = 1'b1; hq(); mSda = 1'b1; hq();
  endtask

  task automatic putBit(input logic b);
    mSda = b; hq(); mScl = 1'b1; hq(); hq(); mScl = 1'b0; hq();
  endtask

  task automatic getBit(output logic b, output bit steady);
    logic early;
    mSda = 1'b1; hq(); mScl = 1'b1; hq();
    early = sdaLine; b = sdaLine; hq();
    steady = (early == sdaLine);
    mScl = 1'b0; hq();
  endtask

  task automatic sendByte(input logic [7:0] v, output bit ack);
    logic b;
    bit s;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(b, s);
    ack = !b;
  endtask

  task automatic recvByte(input bit last);
    logic [7:0] v;
    logic b;
    bit s, allSteady;
    allSteady = 1;
    for (int i = 7; i >= 0; i--) begin
      getBit(b, s);
      v[i] = b;
      allSteady &= s;
    end
    putBit(last);
    check(allSteady, "R11 SDA steady while SCL high", {7'b0, allSteady}, 8'h01);
    gotQ.push_back(v);
  endtask

  task automatic pushExp(input logic [7:0] v, input string tag);
    expItem_t e;
    e.val = v;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic readSeq(input logic [7:0] p, input int n);
    bit ack;
    busStart();
    sendByte(8'h80, ack); check(ack, "R1 write address ack", {7'b0, ack}, 8'h01);
    sendByte(p, ack);     check(ack, "R3 pointer byte ack", {7'b0, ack}, 8'h01);
    busStart();
    sendByte(8'h81, ack); check(ack, "R1 read address ack", {7'b0, ack}, 8'h01);
    for (int i = 0; i < n; i++) recvByte(i == n - 1);
    busStop();
  endtask

  task automatic writeSeq(input logic [7:0] p, input int n, input logic [7:0] a = 0,
                          input logic [7:0] b = 0, input logic [7:0] c = 0);
    bit ack;
    logic [7:0] d[3];
    d = '{a, b, c};
    busStart();
    sendByte(8'h80, ack); check(ack, "R1 write address ack", {7'b0, ack}, 8'h01);
    sendByte(p, ack);     check(ack, "R3 pointer byte ack", {7'b0, ack}, 8'h01);
    for (int i = 0; i < n; i++) begin
      sendByte(d[i], ack);
      check(ack, "R9 data byte ack", {7'b0, ack}, 8'h01);
    end
    busStop();
  endtask

  task automatic settle();
    repeat (4 * Q) @(negedge clk);
  endtask

  initial begin
    bit ack;
    repeat (5) @(negedge clk);
    check(tmdsOff == 1'b0, "R7 reset tmdsOff", {7'b0, tmdsOff}, 8'h00);
    check(cecOn == 1'b0, "R7 reset cecOn", {7'b0, cecOn}, 8'h00);
    check(sdaOe == 1'b0, "R11 reset sdaOe", {7'b0, sdaOe}, 8'h00);
    rstN = 1'b1;
    settle();

    // HDMI content, full sweep 00h-22h (R5, R6, R4, R7, R8)
    for (int i = 0; i < 16; i++) pushExp(idStr[i], "R5 HDMI text");
    pushExp(8'hA0, "R5 HDMI type byte");
    for (int i = 0; i < 12; i++) pushExp(fixedId[i], "R6 fixed id");
    pushExp(8'h88, "R6 TMDS HDMI");
    pushExp(8'h0F, "R6 rate 0");
    pushExp(8'h00, "R9 reserved 1Fh");
    pushExp(8'h00, "R7 reset 20h");
    pushExp(8'h00, "R7 reset 21h");
    pushExp(8'h08, "R8 reset speed");
    readSeq(8'h00, 35);

    rateSel = 1'b1;
    pushExp(8'h1F, "R6 rate 1");
    readSeq(8'h1E, 1);
    rateSel = 1'b0;

    // DVI content (R5, R6)
    hdmiMode = 1'b0;
    for (int i = 0; i < 17; i++) pushExp(8'h00, "R5 DVI zero");
    readSeq(8'h00, 17);
    pushExp(8'h42, "R6 TMDS DVI");
    readSeq(8'h1D, 1);
    hdmiMode = 1'b1;

    // Control bits (R7)
    writeSeq(8'h20, 2, 8'hFF, 8'h01);
    settle();
    check(tmdsOff == 1'b1, "R7 tmdsOff set", {7'b0, tmdsOff}, 8'h01);
    check(cecOn == 1'b1, "R7 cecOn set", {7'b0, cecOn}, 8'h01);
    pushExp(8'h01, "R7 20h upper bits zero");
    pushExp(8'h01, "R7 21h upper bits zero");
    readSeq(8'h20, 2);

    // Aborted byte: STOP after four data bits leaves 20h untouched (R10)
    busStart();
    sendByte(8'h80, ack);
    sendByte(8'h20, ack);
    for (int i = 0; i < 4; i++) putBit(1'b0);
    busStop();
    settle();
    check(tmdsOff == 1'b1, "R10 partial byte discarded", {7'b0, tmdsOff}, 8'h01);

    // Speed register (R8)
    writeSeq(8'h22, 1, 8'h10);
    pushExp(8'h10, "R8 legal 10h kept");
    readSeq(8'h22, 1);
    writeSeq(8'h22, 1, 8'h03);
    pushExp(8'h08, "R8 illegal 03h gives 08h");
    readSeq(8'h22, 1);
    writeSeq(8'h22, 1, 8'h01);
    pushExp(8'h01, "R8 legal 01h kept");
    readSeq(8'h22, 1);

    // Read-only and reserved writes (R9)
    writeSeq(8'h1D, 1, 8'h55);
    writeSeq(8'h30, 1, 8'hAA);
    pushExp(8'h88, "R9 read-only 1Dh unchanged");
    readSeq(8'h1D, 1);
    pushExp(8'h00, "R9 reserved 30h reads zero");
    readSeq(8'h30, 1);

    // Multi-byte write with auto increment (R3)
    writeSeq(8'h20, 3, 8'h00, 8'h00, 8'h02);
    settle();
    check(tmdsOff == 1'b0, "R3 first data byte at 20h", {7'b0, tmdsOff}, 8'h00);
    check(cecOn == 1'b0, "R3 second data byte at 21h", {7'b0, cecOn}, 8'h00);
    pushExp(8'h02, "R3 third data byte at 22h");
    readSeq(8'h22, 1);

    // Pointer wrap (R3, R4)
    pushExp(8'h00, "R4 read FEh");
    pushExp(8'h00, "R4 read FFh");
    pushExp(8'h44, "R3 wrap to 00h");
    readSeq(8'hFE, 3);

    // Wrong address (R1)
    busStart();
    sendByte(8'hA0, ack);
    busStop();
    check(!ack, "R1 foreign address not acked", {7'b0, ack}, 8'h00);

    // Deselected (R2)
    selN = 1'b1;
    busStart();
    sendByte(8'h80, ack);
    busStop();
    check(!ack, "R2 deselected no ack", {7'b0, ack}, 8'h00);
    selN = 1'b0;
    pushExp(8'h44, "R2 reselected works");
    readSeq(8'h00, 1);

    settle();
    check(expQ.size() == 0, "R4 all expected bytes seen", 8'(expQ.size()), 8'h00);
    done = 1;
    finishRun();
  end

endmodule